// File: doc/BRIEF.md
# Rotor Lock-Out Protection Timer

This block guards a spindle motor against a stalled rotor and against a lost speed reference. While the motor is told to run, it counts timebase ticks during which the speed loop reports "not locked". If that count reaches a programmed limit, it latches a shutdown that turns off the low-side drive. A second count measures ticks with no reference-clock edge, and it trips the same latch when the reference disappears. Only a stop command or a power-on reset clears the latch. The unlock count is held at zero while the speed loop slews to a new reference frequency.

The same timebase also times the power-up reset. After power-on, the block holds its reset output high for a fixed number of timebase ticks. If the timebase never ticks, the rest of the logic stays in reset. The block is a four-state machine:

- INIT: power-up reset pulse, left after INIT_TICKS ticks.
- IDLE: stopped, left when the run command rises.
- WATCH: running with both counters active. It goes to TRIP on either expiry and back to IDLE when the run command drops.
- TRIP: shutdown latched, left only for IDLE when the run command drops.

Top module: `rotor_lockout_timer`

## Requirements
- R1: After power-on reset, `init_reset` is 1 and `shutdown` is 0. They stay so, with `run_cmd` ignored, for as long as fewer than INIT_TICKS ticks (`tick`=1 on a rising clock edge) have been seen, including indefinitely when no tick arrives.
- R2: `init_reset` falls in the cycle after the clock edge that samples the INIT_TICKS-th tick.
- R3: While `run_cmd` is 0 outside INIT, `shutdown` stays 0 and neither count advances.
- R4: While running, `shutdown` rises in the cycle after the edge that samples the UNLOCK_TICKS-th consecutive tick with `locked`=0 and `decel`=0.
- R5: Any cycle with `locked`=1 while running resets the unlock count to zero.
- R6: Any cycle with `decel`=1 while running resets the unlock count to zero, so unlocked deceleration never trips the shutdown by itself.
- R7: While running, `shutdown` rises in the cycle after the edge that samples the MISS_TICKS-th tick with no `ref_edge` since entry or since the last `ref_edge`. A `ref_edge` in a cycle resets that count, and a `ref_edge` in the same cycle as a tick wins.
- R8: Once set, `shutdown` stays 1 while `run_cmd` stays 1, whatever `locked`, `decel`, `ref_edge` and `tick` do.
- R9: `shutdown` falls in the cycle after `run_cmd` is sampled 0. A new run command starts both counts from zero.
- R10: `shutdown` and `init_reset` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| run_cmd | input | 1 | 1 = motor commanded to run, 0 = stop |
| locked | input | 1 | 1 = speed loop reports phase lock |
| decel | input | 1 | 1 = deceleration after a reference frequency change |
| ref_edge | input | 1 | One-cycle pulse per reference clock edge |
| tick | input | 1 | One-cycle pulse from the protection timebase |
| shutdown | output | 1 | Latched low-side drive shutdown |
| init_reset | output | 1 | Power-up reset for the surrounding logic |

## Verification
The bench holds the timebase silent after power-up. A design that released the reset early, or on the run command, would show `init_reset` low too soon. It places a single locked cycle or a decel pulse one tick before expiry, where a design that only paused its count would trip. It removes reference edges while lock is held, where a design that tied clock-loss detection to the unlock path would never trip. It also toggles inputs after a trip, so a latch that followed the lock status would release while still running. A random phase with frequent stops, lock changes and ref edge/tick coincidences is compared cycle by cycle against a model of the requirements.

// File: rtl/lko_pkg.sv
package lko_pkg;
    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_WATCH = 2'd2,
        ST_TRIP  = 2'd3
    } lko_state_t;
endpackage

// File: rtl/lko_tick_counter.sv
// Counts advance pulses; expire pulses combinationally on the LIMIT-th one.
module lko_tick_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic expire
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;
    logic         at_last;

    assign at_last = (cnt == LAST);
    assign expire  = advance && !clear && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (advance)
            cnt <= at_last ? '0 : cnt + 1'b1;
    end

    // R4
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R5
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
endmodule

// File: rtl/rotor_lockout_timer.sv
module rotor_lockout_timer
    import lko_pkg::*;
#(
    parameter int INIT_TICKS   = 4,
    parameter int UNLOCK_TICKS = 800,
    parameter int MISS_TICKS   = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_cmd,
    input  logic locked,
    input  logic decel,
    input  logic ref_edge,
    input  logic tick,
    output logic shutdown,
    output logic init_reset
);
    lko_state_t state, state_nx;
    logic init_exp, unl_exp, miss_exp;
    logic watching;

    assign watching = (state == ST_WATCH);

    lko_tick_counter #(.LIMIT(INIT_TICKS)) u_init_cnt (
        .clk(clk), .rst_n(rst_n),
        .clear(state != ST_INIT), .advance(tick), .expire(init_exp));

    lko_tick_counter #(.LIMIT(UNLOCK_TICKS)) u_unlock_cnt (
        .clk(clk), .rst_n(rst_n),
        .clear(!watching || locked || decel), .advance(tick), .expire(unl_exp));

    lko_tick_counter #(.LIMIT(MISS_TICKS)) u_miss_cnt (
        .clk(clk), .rst_n(rst_n),
        .clear(!watching || ref_edge), .advance(tick), .expire(miss_exp));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_INIT;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT:  if (init_exp) state_nx = ST_IDLE;
            ST_IDLE:  if (run_cmd) state_nx = ST_WATCH;
            ST_WATCH: begin
                if (!run_cmd)
                    state_nx = ST_IDLE;
                else if (unl_exp || miss_exp)
                    state_nx = ST_TRIP;
            end
            ST_TRIP:  if (!run_cmd) state_nx = ST_IDLE;
            default:  state_nx = ST_INIT;
        endcase
    end

    always_comb begin
        shutdown   = (state == ST_TRIP);
        init_reset = (state == ST_INIT);
    end

    // R10
    no_dual_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shutdown && init_reset));

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && run_cmd) |=> shutdown);

    // R9
    release_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown) |-> !$past(run_cmd));

    // R4
    trip_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown) |-> ($past(tick) && $past(run_cmd)));

    // R2
    init_end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_reset) |-> $past(tick));
endmodule

// File: tb/rotor_lockout_timer_bench.sv
module rotor_lockout_timer_bench;
    localparam int INIT_T = 4;
    localparam int UNL_T  = 12;
    localparam int MISS_T = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_cmd = 0, locked = 0, decel = 0, ref_edge = 0, tick = 0;
    logic shutdown, init_reset;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    rotor_lockout_timer #(.INIT_TICKS(INIT_T), .UNLOCK_TICKS(UNL_T),
                          .MISS_TICKS(MISS_T)) u_rotor_lockout_timer (
        .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .locked(locked),
        .decel(decel), .ref_edge(ref_edge), .tick(tick),
        .shutdown(shutdown), .init_reset(init_reset));

    // Requirement model: 0 init, 1 stopped, 2 running, 3 tripped
    int m_st = 0, m_init = 0, m_unl = 0, m_miss = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_st <= 0; m_init <= 0; m_unl <= 0; m_miss <= 0;
        end else begin
            case (m_st)
                0: if (tick) begin
                       if (m_init + 1 == INIT_T) begin m_st <= 1; m_init <= 0; end
                       else m_init <= m_init + 1;
                   end
                1: begin
                       m_unl <= 0; m_miss <= 0;
                       if (run_cmd) m_st <= 2;
                   end
                2: begin
                       if (!run_cmd) begin
                           m_st <= 1; m_unl <= 0; m_miss <= 0;
                       end else begin
                           if (tick && !locked && !decel && m_unl + 1 == UNL_T) m_st <= 3;
                           if (tick && !ref_edge && m_miss + 1 == MISS_T) m_st <= 3;
                           m_unl  <= (locked || decel) ? 0 : (tick ? m_unl + 1 : m_unl);
                           m_miss <= ref_edge ? 0 : (tick ? m_miss + 1 : m_miss);
                       end
                   end
                default: if (!run_cmd) begin m_st <= 1; m_unl <= 0; m_miss <= 0; end
            endcase
        end
    end

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    task automatic cyc(input logic r, input logic l, input logic d, input logic e, input logic t);
        run_cmd = r; locked = l; decel = d; ref_edge = e; tick = t;
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, shutdown, (m_st == 3), "shutdown vs model");
        chk(cur_req, init_reset, (m_st == 0), "init_reset vs model");
        chk("R10", shutdown && init_reset, 1'b0, "both outputs high");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1", init_reset, 1'b1, "init_reset during reset");
        chk("R1", shutdown, 1'b0, "shutdown during reset");
        rst_n = 1'b1;

        // R1: no ticks -> stays in reset, run ignored
        cur_req = "R1";
        for (int i = 0; i < 25; i++) cyc(1, 0, 0, 0, 0);
        chk("R1", init_reset, 1'b1, "held with silent timebase");

        // R2: exact release after INIT_T ticks
        cur_req = "R2";
        for (int i = 0; i < INIT_T - 1; i++) cyc(0, 0, 0, 0, 1);
        chk("R2", init_reset, 1'b1, "one tick before release");
        cyc(0, 0, 0, 0, 1);
        chk("R2", init_reset, 1'b0, "released after last tick");

        // R3: stopped, unlocked, no ref
        cur_req = "R3";
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 1);
        chk("R3", shutdown, 1'b0, "no trip while stopped");

        // R4: unlock timeout with ref present
        cur_req = "R4";
        cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < UNL_T - 1; i++) cyc(1, 0, 0, (i % 4) == 0, 1);
        chk("R4", shutdown, 1'b0, "one tick before unlock limit");
        cyc(1, 0, 0, 0, 1);
        chk("R4", shutdown, 1'b1, "trip on unlock limit");

        // R8: latched while running
        cur_req = "R8";
        for (int i = 0; i < 15; i++) cyc(1, 1, i[0], 1, 1);
        chk("R8", shutdown, 1'b1, "latch holds with lock regained");

        // R9: stop releases
        cur_req = "R9";
        cyc(0, 1, 0, 1, 0);
        chk("R9", shutdown, 1'b0, "release after stop");

        // R5: lock one cycle before limit resets count
        cur_req = "R5";
        cyc(1, 0, 0, 1, 0);
        for (int i = 0; i < UNL_T - 1; i++) cyc(1, 0, 0, 1, 1);
        cyc(1, 1, 0, 1, 0);
        for (int i = 0; i < UNL_T - 1; i++) cyc(1, 0, 0, 1, 1);
        chk("R5", shutdown, 1'b0, "count restarted after lock");
        cyc(1, 0, 0, 1, 1);
        chk("R5", shutdown, 1'b1, "trip after full fresh window");
        cyc(0, 0, 0, 0, 0);

        // R6: decel inhibits unlock trip
        cur_req = "R6";
        cyc(1, 0, 0, 1, 0);
        for (int i = 0; i < 3 * UNL_T; i++) cyc(1, 0, (i % UNL_T) == UNL_T - 2, 1, 1);
        cyc(0, 0, 0, 0, 0);
        cyc(1, 0, 1, 1, 0);
        for (int i = 0; i < 3 * UNL_T; i++) cyc(1, 0, 1, 1, 1);
        chk("R6", shutdown, 1'b0, "no trip while decelerating");
        cyc(0, 0, 0, 0, 0);

        // R7: missing reference while locked
        cur_req = "R7";
        cyc(1, 1, 0, 0, 0);
        for (int i = 0; i < MISS_T - 1; i++) cyc(1, 1, 0, 0, 1);
        cyc(1, 1, 0, 1, 1);
        for (int i = 0; i < MISS_T - 1; i++) cyc(1, 1, 0, 0, 1);
        chk("R7", shutdown, 1'b0, "ref edge with tick reset count");
        cyc(1, 1, 0, 0, 1);
        chk("R7", shutdown, 1'b1, "trip on missing reference");
        cyc(0, 1, 0, 1, 0);

        // random phase
        cur_req = "R10";
        for (int i = 0; i < 6000; i++) begin
            cyc(($urandom % 60) != 0, ($urandom % 3) == 0, ($urandom % 12) == 0,
                ($urandom % 9) == 0, ($urandom % 2) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule